// File: doc/BRIEF.md
# Conversion Result Bank with Overwrite Detection

This block holds the results of a multi-conversion sequence in ten slots of ten bits each. The conversion sequencer pushes each result with a slot index on a valid/ready write channel. A host reads individual slots through an address and read-strobe port, and the stored value comes back one cycle later. Every slot carries an unread marker. A write sets the marker and a host read of that slot clears it.

A sticky error flag records that a fresh result replaced a value the host had not yet fetched. The flag can only be raised while the converter runs a buffered free-running sequence or a channel scan, either once or looping. When the converter is started again, a one-cycle restart pulse clears the flag. The restart leaves the stored data and the unread markers alone.

The write channel never applies back-pressure: `wr_ready` is held high, and a write takes effect on every clock edge where `wr_valid` is high. The read port has no handshake. A strobe is always served, and its answer appears together with `rd_valid` in the following cycle.

Top module: `rbuf_top`

## Requirements
- R1: After reset, `slot_full` is all zeros, `overrun` is 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A write with `wr_valid` high and `wr_idx` below 10 stores `wr_data` in that slot and sets bit `wr_idx` of `slot_full` at the same clock edge. `wr_ready` is always 1.
- R3: A read strobe (`rd_en`) with `rd_addr` below 10 drives the stored value on `rd_data` with `rd_valid` high in the next cycle only. It also clears bit `rd_addr` of `slot_full`, unless a write to the same slot happens in the same cycle.
- R4: The `mode` input is encoded 0 = one-shot, 1 = free-running, 2 = free-running buffered, 3 = scan once, 4 = scan loop; codes 5 to 7 are reserved. In modes 2, 3 and 4, an in-range write to a slot whose `slot_full` bit is set raises `overrun` at that clock edge.
- R5: In modes 0 and 1, and under codes 5 to 7, `overrun` is never raised.
- R6: A write and a read to the same slot in the same cycle is not an overwrite. `overrun` is unchanged, the slot keeps its `slot_full` bit set and holds the new data, and the read returns the old value.
- R7: Once set, `overrun` stays set through further overwrites, reads and mode changes until a restart.
- R8: A `restart` pulse clears `overrun` at the next edge, even if an overwrite happens in the same cycle. It does not change stored data or `slot_full`.
- R9: A write with `wr_idx` of 10 or more changes no slot, no `slot_full` bit and not `overrun`.
- R10: A read strobe with `rd_addr` of 10 or more returns 0 with `rd_valid` high and changes no `slot_full` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Conversion mode code (see R4) |
| restart | input | 1 | Converter restart pulse; clears the overrun flag |
| wr_valid | input | 1 | Result write valid |
| wr_ready | output | 1 | Write accept; always 1 |
| wr_idx | input | 4 | Slot index of the result |
| wr_data | input | 10 | Conversion result |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Slot to read |
| rd_data | output | 10 | Read result, registered |
| rd_valid | output | 1 | `rd_data` carries a read answer |
| slot_full | output | 10 | Per-slot unread markers |
| overrun | output | 1 | Sticky overwrite error |

## Verification
On every cycle the assertions check several timing rules:
- the one-cycle read latency, and that a plain read clears the slot's marker;
- that a write sets the slot's marker;
- that an armed overwrite raises the flag, and that the flag stays set until a restart;
- that a restart clears the flag, and that unarmed modes, ignored indexes and out-of-range reads leave the flag and the returned data as required.

Only the bench's scenarios can show that each slot returns exactly the value written to it. The same holds for the old-value answer on a same-cycle read and write, restart winning over a simultaneous overwrite, and restart leaving the data and markers untouched.

// File: rtl/rbuf_pkg.sv
package rbuf_pkg;

  typedef enum logic [2:0] {
    MODE_ONE_SHOT     = 3'd0,
    MODE_FREE_RUN     = 3'd1,
    MODE_FREE_RUN_BUF = 3'd2,
    MODE_SCAN_ONCE    = 3'd3,
    MODE_SCAN_LOOP    = 3'd4
  } conv_mode_e;

  // True for the modes that fill the bank with several results.
  function automatic logic mode_arms_ovr(logic [2:0] m);
    return (m == MODE_FREE_RUN_BUF) || (m == MODE_SCAN_ONCE) ||
           (m == MODE_SCAN_LOOP);
  endfunction

endpackage

// File: rtl/rbuf_slot.sv
module rbuf_slot #(
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q,
  output logic              full,
  output logic              overwrite
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      full <= 1'b0;
    end else begin
      if (wr_hit) q <= wr_data;
      if (wr_hit)      full <= 1'b1;
      else if (rd_hit) full <= 1'b0;
    end
  end

  // An unread value is lost unless the host takes it in the same cycle.
  assign overwrite = wr_hit && full && !rd_hit;

endmodule

// File: rtl/rbuf_ovr_flag.sv
module rbuf_ovr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic armed,
  input  logic overwrite_any,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag <= 1'b0;
    else if (restart)                 flag <= 1'b0;
    else if (armed && overwrite_any)  flag <= 1'b1;
  end

endmodule

// File: rtl/rbuf_rd_port.sv
module rbuf_rd_port #(
  parameter int unsigned NUM_SLOTS = 10,
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  slot_q,
  input  logic                              rd_en,
  input  logic [IDX_W-1:0]                  rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid
);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_addr == IDX_W'(i)) sel = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

endmodule

// File: rtl/rbuf_top.sv
module rbuf_top #(
  parameter int unsigned NUM_SLOTS = 10,
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           mode,
  input  logic                 restart,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [NUM_SLOTS-1:0] slot_full,
  output logic                 overrun
);

  logic [NUM_SLOTS-1:0]             wr_hit, rd_hit, ovw;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
  logic                             wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign wr_hit[i] = wr_fire && (wr_idx == IDX_W'(i));
    assign rd_hit[i] = rd_en && (rd_addr == IDX_W'(i));

    rbuf_slot #(.DATA_W(DATA_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit[i]),
      .rd_hit    (rd_hit[i]),
      .wr_data   (wr_data),
      .q         (slot_q[i]),
      .full      (slot_full[i]),
      .overwrite (ovw[i])
    );
  end

  rbuf_ovr_flag u_ovr (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .armed         (rbuf_pkg::mode_arms_ovr(mode)),
    .overwrite_any (|ovw),
    .flag          (overrun)
  );

  rbuf_rd_port #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_q   (slot_q),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/rbuf_checker.sv
module rbuf_checker #(
  parameter int unsigned NUM_SLOTS = 10,
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           mode,
  input logic                 restart,
  input logic                 wr_valid,
  input logic [IDX_W-1:0]     wr_idx,
  input logic                 rd_en,
  input logic [IDX_W-1:0]     rd_addr,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 rd_valid,
  input logic [NUM_SLOTS-1:0] slot_full,
  input logic                 overrun
);

  logic wr_in, rd_in, armed;
  logic [NUM_SLOTS-1:0] wr_mask, rd_mask;

  assign wr_in   = wr_valid && (wr_idx < IDX_W'(NUM_SLOTS));
  assign rd_in   = rd_en && (rd_addr < IDX_W'(NUM_SLOTS));
  assign wr_mask = wr_in ? (NUM_SLOTS'(1) << wr_idx) : '0;
  assign rd_mask = rd_in ? (NUM_SLOTS'(1) << rd_addr) : '0;
  assign armed   = (mode == 3'd2) || (mode == 3'd3) || (mode == 3'd4);

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R3
  AST_RD_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in && !(wr_valid && wr_idx == rd_addr) |=> !(|(slot_full & $past(rd_mask)))); // R3
  AST_WR_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> |(slot_full & $past(wr_mask))); // R2
  AST_OVR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in && armed && !restart && (|(slot_full & wr_mask)) &&
    !(rd_en && rd_addr == wr_idx) |=> overrun); // R4
  AST_OVR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun && !armed |=> !overrun); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !restart |=> overrun); // R7
  AST_OVR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !overrun); // R8
  AST_OOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_in && !rd_en && !restart |=> $stable(overrun) && $stable(slot_full)); // R9
  AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_in |=> rd_data == '0); // R10

endmodule

bind rbuf_top rbuf_checker #(
  .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .slot_full(slot_full),
  .overrun(overrun)
);

// File: tb/tb_rbuf_top.sv
`timescale 1ns/1ps
module tb_rbuf_top;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] mode = 3'd2;
  logic       restart = 0;
  logic       wr_valid = 0;
  logic       wr_ready;
  logic [3:0] wr_idx = 0;
  logic [9:0] wr_data = 0;
  logic       rd_en = 0;
  logic [3:0] rd_addr = 0;
  logic [9:0] rd_data;
  logic       rd_valid;
  logic [9:0] slot_full;
  logic       overrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rbuf_top dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .restart(restart),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .slot_full(slot_full), .overrun(overrun)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle; outputs reflect the edge when this returns.
  task automatic cyc(input logic w, input logic [3:0] wi, input logic [9:0] wd,
                     input logic r, input logic [3:0] ra, input logic rs);
    wr_valid = w; wr_idx = wi; wr_data = wd; rd_en = r; rd_addr = ra; restart = rs;
    @(negedge clk);
    wr_valid = 0; rd_en = 0; restart = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [9:0] d);
    cyc(1, i, d, 0, 0, 0);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(0, 0, 0, 1, a, 0);
  endtask

  task automatic pulse_restart();
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic drain();
    for (int i = 0; i < 10; i++) rd(4'(i));
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(slot_full, 0, "R1", "slot_full after reset");
    chk(overrun, 0, "R1", "overrun after reset");
    chk(rd_valid, 0, "R1", "rd_valid after reset");
    chk(rd_data, 0, "R1", "rd_data after reset");
    chk(wr_ready, 1, "R2", "wr_ready");
  endtask

  task automatic t_fill_and_read();
    mode = 3'd2;
    for (int i = 0; i < 10; i++) wr(4'(i), 10'((i * 37 + 5) & 10'h3ff));
    chk(slot_full, 10'h3ff, "R2", "all slots marked");
    chk(overrun, 0, "R4", "no overrun on first fill");
    for (int i = 0; i < 10; i++) begin
      rd(4'(i));
      chk(rd_valid, 1, "R3", "rd_valid after strobe");
      chk(rd_data, 10'((i * 37 + 5) & 10'h3ff), "R3", "slot data");
    end
    @(negedge clk);
    chk(rd_valid, 0, "R3", "rd_valid drops");
    chk(slot_full, 0, "R3", "markers cleared by reads");
  endtask

  task automatic t_armed_modes();
    for (int m = 2; m <= 4; m++) begin
      mode = 3'(m);
      pulse_restart();
      chk(overrun, 0, "R8", "cleared before test");
      wr(4'd3, 10'h111);
      chk(overrun, 0, "R4", "first write no overrun");
      wr(4'd3, 10'h222);
      chk(overrun, 1, "R4", "overwrite raises flag");
      wr(4'd3, 10'h333);
      rd(4'd3);
      chk(rd_data, 10'h333, "R2", "latest value kept");
      mode = 3'd0;
      @(negedge clk);
      chk(overrun, 1, "R7", "sticky across read and mode change");
      wr(4'd4, 10'h044);
      pulse_restart();
      chk(overrun, 0, "R8", "restart clears flag");
      chk(slot_full, 10'h010, "R8", "restart keeps markers");
      rd(4'd4);
      chk(rd_data, 10'h044, "R8", "restart keeps data");
    end
  endtask

  task automatic t_plain_modes();
    logic [2:0] ml [3] = '{3'd0, 3'd1, 3'd6};
    for (int k = 0; k < 3; k++) begin
      mode = ml[k];
      pulse_restart();
      wr(4'd5, 10'h0aa);
      wr(4'd5, 10'h0bb);
      chk(overrun, 0, "R5", "unarmed mode overwrite");
      rd(4'd5);
      chk(rd_data, 10'h0bb, "R5", "data in unarmed mode");
    end
  endtask

  task automatic t_same_cycle();
    mode = 3'd3;
    pulse_restart();
    wr(4'd2, 10'h1a1);
    cyc(1, 4'd2, 10'h2b2, 1, 4'd2, 0);
    chk(rd_data, 10'h1a1, "R6", "read returns old value");
    chk(overrun, 0, "R6", "no overrun on same-cycle read");
    chk(slot_full[2], 1, "R6", "marker stays set");
    rd(4'd2);
    chk(rd_data, 10'h2b2, "R6", "new value stored");
  endtask

  task automatic t_out_of_range();
    mode = 3'd4;
    pulse_restart();
    wr(4'd0, 10'h0c0);
    wr(4'd10, 10'h3ff);
    wr(4'd15, 10'h155);
    chk(slot_full, 10'h001, "R9", "markers unchanged by bad index");
    chk(overrun, 0, "R9", "flag unchanged by bad index");
    rd(4'd12);
    chk(rd_valid, 1, "R10", "rd_valid for bad address");
    chk(rd_data, 0, "R10", "zero for bad address");
    chk(slot_full, 10'h001, "R10", "markers unchanged by bad read");
    rd(4'd0);
    chk(rd_data, 10'h0c0, "R9", "slot 0 not aliased");
  endtask

  task automatic t_restart_priority();
    mode = 3'd2;
    pulse_restart();
    wr(4'd7, 10'h077);
    cyc(1, 4'd7, 10'h078, 0, 0, 1);
    chk(overrun, 0, "R8", "restart beats overwrite");
    wr(4'd7, 10'h079);
    chk(overrun, 1, "R4", "later overwrite raises");
    pulse_restart();
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_and_read();
    t_armed_modes();
    t_plain_modes();
    t_same_cycle();
    t_out_of_range();
    t_restart_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule